// File: doc/BRIEF.md
# DDR SDRAM Power-Up Sequencer

This block sits on the controller side of a DDR SDRAM interface. After a synchronous reset, it takes the memory from an unpowered-looking idle state to a state where normal traffic may start. It holds clock enable low while the clock settles. It then raises clock enable and issues a fixed chain of commands: a precharge of all banks, a write of the extended mode register that turns the DLL on, and a mode register write that resets the DLL. A second precharge of all banks follows, then a parameterized number of auto-refresh commands, and a final mode register write that sets the operating mode.

Every wait is a count of clock cycles, and each count is a parameter. The settling period stands for 200 µs. The block does not model supplies or the DLL itself. A separate lock counter runs alongside the command chain. The ready flag therefore rises only when both the DLL lock window and the recovery time after the last mode write have elapsed. The flag stays high until the next reset. From then on the command pins carry only NOPs.

Top module: `ddr_powerup_seq`

## Requirements
- R1: While reset is high, and on the cycle after any clock edge that samples reset high, `cke` is 0, the command pins show NOP (`cs_n`=0, `ras_n`=1, `cas_n`=1, `we_n`=1), `ba` and `addr` are 0, and `init_done` is 0.
- R2: After reset is released, `cke` stays low for exactly STABLE_CYC clock cycles. It then rises and stays high until the next reset. While `cke` is low, the pins show NOP.
- R3: The only non-NOP commands form this sequence, in this order: precharge-all, extended mode write, mode write with DLL reset, precharge-all, REF_COUNT auto-refreshes, and final mode write. Every other cycle shows NOP.
- R4: A precharge-all is coded `cs_n,ras_n,cas_n,we_n` = 0,0,1,0, with `addr[10]`=1, every other address bit 0 and `ba`=0.
- R5: The extended mode write is coded 0,0,0,0 with `ba`=2'b01 (bank bit 0 high). `addr` is all zero, so that `addr[0]`=0 enables the DLL.
- R6: Both mode writes are coded 0,0,0,0 with `ba`=0. They carry `addr[2:0]`=`mode_bl`, `addr[3]`=`mode_bt` and `addr[6:4]`=`mode_cl`, with `addr[7]`=0 and `addr[11:9]`=0. `addr[8]` is 1 on the first mode write (DLL reset) and 0 on the final one.
- R7: Each command follows the previous event after an exact number of cycles, set by that previous event. The rise of `cke` is followed after CKE_NOP_CYC cycles, a precharge after RP_CYC, an extended or normal mode write after MRD_CYC, and an auto-refresh after RFC_CYC.
- R8: `init_done` rises MRD_CYC cycles after the final mode write appears, or DLL_LOCK_CYC cycles after the DLL-reset mode write appears, whichever is later.
- R9: Once `init_done` is high, it stays high until reset. Meanwhile `cke` stays high and the pins show NOP.
- R10: The number of auto-refresh commands equals the REF_COUNT parameter. The default is 2; the bench builds with 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset; restarts the sequence |
| mode_bl | input | 3 | Burst length code placed on addr[2:0] of both mode writes |
| mode_bt | input | 1 | Burst type bit placed on addr[3] |
| mode_cl | input | 3 | CAS latency code placed on addr[6:4] |
| cke | output | 1 | Clock enable to the memory, registered |
| cs_n | output | 1 | Chip select, active low, registered |
| ras_n | output | 1 | Row strobe, active low, registered |
| cas_n | output | 1 | Column strobe, active low, registered |
| we_n | output | 1 | Write enable, active low, registered |
| ba | output | BA_W | Bank address bits |
| addr | output | ADDR_W | Address bits (mode fields, all-bank flag) |
| init_done | output | 1 | High once the memory may accept reads; held until reset |

## Verification
The assertions assume that the timing parameters are at least 1 and MRD_CYC is at least 2. Under that assumption, a mode write is always followed by a NOP cycle. They also assume that reset is applied synchronously from time zero, and that the mode inputs do not change while a sequence runs. The bench drives reset and the mode inputs only on falling edges. It holds each set of mode values fixed from before reset release until `init_done`. It changes them only under reset, including a reset that cuts a sequence short part-way through.

// File: rtl/pus_pkg.sv
package pus_pkg;

  typedef enum logic [3:0] {
    ST_STABLE,
    ST_CKE,
    ST_PRE1,
    ST_EMRS,
    ST_MRS_DLL,
    ST_PRE2,
    ST_REF,
    ST_MRS_RUN,
    ST_LOCK,
    ST_DONE
  } step_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } pins_t;

  localparam pins_t CMD_NOP = pins_t'(4'b0111);
  localparam pins_t CMD_PRE = pins_t'(4'b0010);
  localparam pins_t CMD_REF = pins_t'(4'b0001);
  localparam pins_t CMD_MRS = pins_t'(4'b0000);

  // mode word field positions decoded by the memory
  localparam int BL_LSB     = 0;
  localparam int BT_BIT     = 3;
  localparam int CL_LSB     = 4;
  localparam int DLLRST_BIT = 8;
  localparam int ALLBNK_BIT = 10;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/pus_down_timer.sv
module pus_down_timer #(
  parameter int W      = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= W'(RST_VAL);
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/pus_cmd_encode.sv
module pus_cmd_encode
  import pus_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BA_W   = 2
) (
  input  step_e             step,
  input  logic [2:0]        mode_bl,
  input  logic              mode_bt,
  input  logic [2:0]        mode_cl,
  output pins_t             pins,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o
);

  always_comb begin
    pins   = CMD_NOP;
    ba_o   = '0;
    addr_o = '0;
    case (step)
      ST_PRE1, ST_PRE2: begin
        pins               = CMD_PRE;
        addr_o[ALLBNK_BIT] = 1'b1;
      end
      ST_EMRS: begin
        // extended register select; address zero keeps the DLL enabled
        pins    = CMD_MRS;
        ba_o[0] = 1'b1;
      end
      ST_MRS_DLL, ST_MRS_RUN: begin
        pins                       = CMD_MRS;
        addr_o[BL_LSB +: 3]        = mode_bl;
        addr_o[BT_BIT]             = mode_bt;
        addr_o[CL_LSB +: 3]        = mode_cl;
        addr_o[DLLRST_BIT]         = (step == ST_MRS_DLL);
      end
      ST_REF: begin
        pins = CMD_REF;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ddr_powerup_seq.sv
module ddr_powerup_seq
  import pus_pkg::*;
#(
  parameter int STABLE_CYC   = 50000,
  parameter int CKE_NOP_CYC  = 1,
  parameter int RP_CYC       = 5,
  parameter int MRD_CYC      = 2,
  parameter int RFC_CYC      = 18,
  parameter int DLL_LOCK_CYC = 200,
  parameter int REF_COUNT    = 2,
  parameter int ADDR_W       = 12,
  parameter int BA_W         = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode_bl,
  input  logic              mode_bt,
  input  logic [2:0]        mode_cl,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);

  localparam int LONGEST = imax(imax(imax(STABLE_CYC, CKE_NOP_CYC), imax(RP_CYC, MRD_CYC)),
                                imax(RFC_CYC, DLL_LOCK_CYC));
  localparam int TW  = $clog2(LONGEST + 1);
  localparam int RCW = $clog2(REF_COUNT + 1);

  localparam logic [TW-1:0] LD_STABLE = TW'(STABLE_CYC - 1);
  localparam logic [TW-1:0] LD_CKE    = TW'(CKE_NOP_CYC - 1);
  localparam logic [TW-1:0] LD_RP     = TW'(RP_CYC - 1);
  localparam logic [TW-1:0] LD_MRD    = TW'(MRD_CYC - 1);
  localparam logic [TW-1:0] LD_RFC    = TW'(RFC_CYC - 1);
  localparam logic [TW-1:0] LD_LOCK   = TW'(DLL_LOCK_CYC - 1);
  localparam logic [RCW-1:0] REF_LAST = RCW'(REF_COUNT - 1);

  step_e          step_q, step_d;
  logic [RCW-1:0] ref_q, ref_d;
  logic           gap_zero, lock_zero;
  logic           gap_load, lock_load;
  logic [TW-1:0]  gap_val;
  logic           issue, cke_set, done_set;

  pins_t             enc_pins;
  logic [BA_W-1:0]   enc_ba;
  logic [ADDR_W-1:0] enc_addr;

  pins_t             pins_q;
  logic [BA_W-1:0]   ba_q;
  logic [ADDR_W-1:0] addr_q;
  logic              cke_q, done_q;

  // spacing between consecutive events
  pus_down_timer #(.W(TW), .RST_VAL(0)) u_gap (
    .clk(clk), .rst(rst), .load(gap_load), .load_val(gap_val), .zero(gap_zero)
  );

  // DLL lock window, restarted by each DLL enable or reset
  pus_down_timer #(.W(TW), .RST_VAL(DLL_LOCK_CYC - 1)) u_lock (
    .clk(clk), .rst(rst), .load(lock_load), .load_val(LD_LOCK), .zero(lock_zero)
  );

  pus_cmd_encode #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_enc (
    .step(step_q), .mode_bl(mode_bl), .mode_bt(mode_bt), .mode_cl(mode_cl),
    .pins(enc_pins), .ba_o(enc_ba), .addr_o(enc_addr)
  );

  always_comb begin
    step_d    = step_q;
    ref_d     = ref_q;
    gap_load  = 1'b0;
    gap_val   = '0;
    lock_load = 1'b0;
    issue     = 1'b0;
    cke_set   = 1'b0;
    done_set  = 1'b0;
    if (gap_zero) begin
      case (step_q)
        ST_STABLE: begin
          gap_load = 1'b1; gap_val = LD_STABLE; step_d = ST_CKE;
        end
        ST_CKE: begin
          cke_set = 1'b1; gap_load = 1'b1; gap_val = LD_CKE; step_d = ST_PRE1;
        end
        ST_PRE1: begin
          issue = 1'b1; gap_load = 1'b1; gap_val = LD_RP; step_d = ST_EMRS;
        end
        ST_EMRS: begin
          issue = 1'b1; gap_load = 1'b1; gap_val = LD_MRD; lock_load = 1'b1;
          step_d = ST_MRS_DLL;
        end
        ST_MRS_DLL: begin
          issue = 1'b1; gap_load = 1'b1; gap_val = LD_MRD; lock_load = 1'b1;
          step_d = ST_PRE2;
        end
        ST_PRE2: begin
          issue = 1'b1; gap_load = 1'b1; gap_val = LD_RP; step_d = ST_REF;
        end
        ST_REF: begin
          issue = 1'b1; gap_load = 1'b1; gap_val = LD_RFC;
          if (ref_q == REF_LAST) begin
            ref_d  = '0;
            step_d = ST_MRS_RUN;
          end else begin
            ref_d = ref_q + 1'b1;
          end
        end
        ST_MRS_RUN: begin
          issue = 1'b1; gap_load = 1'b1; gap_val = LD_MRD; step_d = ST_LOCK;
        end
        ST_LOCK: begin
          if (lock_zero) begin
            done_set = 1'b1; step_d = ST_DONE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= ST_STABLE;
      ref_q  <= '0;
      pins_q <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      cke_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      step_q <= step_d;
      ref_q  <= ref_d;
      pins_q <= issue ? enc_pins : CMD_NOP;
      ba_q   <= issue ? enc_ba : '0;
      addr_q <= issue ? enc_addr : '0;
      cke_q  <= cke_q | cke_set;
      done_q <= done_q | done_set;
    end
  end

  assign cke       = cke_q;
  assign cs_n      = pins_q.cs_n;
  assign ras_n     = pins_q.ras_n;
  assign cas_n     = pins_q.cas_n;
  assign we_n      = pins_q.we_n;
  assign ba        = ba_q;
  assign addr      = addr_q;
  assign init_done = done_q;

  // R2: clock enable never drops once raised
  assert_cke_held_R2: assert property (@(posedge clk) disable iff (rst)
    cke_q |=> cke_q);

  // R2: no command while clock enable is low
  assert_cke_low_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !cke_q |-> (pins_q == CMD_NOP));

  // R4: every precharge selects all banks
  assert_pre_all_R4: assert property (@(posedge clk) disable iff (rst)
    (pins_q == CMD_PRE) |-> (addr_q[ALLBNK_BIT] && ba_q == '0));

  // R5: extended write carries an all-zero address
  assert_emrs_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (pins_q == CMD_MRS && ba_q[0]) |-> (addr_q == '0));

  // R6: normal mode writes keep the test bit low
  assert_mrs_test_low_R6: assert property (@(posedge clk) disable iff (rst)
    (pins_q == CMD_MRS && ba_q == '0) |-> !addr_q[7]);

  // R7: a mode write is followed by at least one NOP cycle
  assert_mrs_recovery_R7: assert property (@(posedge clk) disable iff (rst)
    (pins_q == CMD_MRS) |=> (pins_q == CMD_NOP));

  // R9: ready flag is sticky
  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    done_q |=> done_q);

  // R9: after ready, clock enable high and bus idle
  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    done_q |-> (cke_q && pins_q == CMD_NOP));

endmodule

// File: tb/ddr_powerup_seq_bench.sv
`timescale 1ns/1ps
module ddr_powerup_seq_bench;

  localparam int STABLE = 40;
  localparam int CKENOP = 1;
  localparam int RP     = 3;
  localparam int MRD    = 2;
  localparam int RFC    = 9;
  localparam int LOCK   = 200;
  localparam int NREF   = 3;

  localparam logic [3:0] P_NOP = 4'b0111;
  localparam logic [3:0] P_PRE = 4'b0010;
  localparam logic [3:0] P_REF = 4'b0001;
  localparam logic [3:0] P_MRS = 4'b0000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1;
  logic [2:0]  mode_bl = 3'd0;
  logic        mode_bt = 1'b0;
  logic [2:0]  mode_cl = 3'd0;
  logic        cke, cs_n, ras_n, cas_n, we_n, init_done;
  logic [1:0]  ba;
  logic [11:0] addr;

  ddr_powerup_seq #(
    .STABLE_CYC(STABLE), .CKE_NOP_CYC(CKENOP), .RP_CYC(RP), .MRD_CYC(MRD),
    .RFC_CYC(RFC), .DLL_LOCK_CYC(LOCK), .REF_COUNT(NREF), .ADDR_W(12), .BA_W(2)
  ) u_ddr_powerup_seq (
    .clk(clk), .rst(rst), .mode_bl(mode_bl), .mode_bt(mode_bt), .mode_cl(mode_cl),
    .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .init_done(init_done)
  );

  typedef struct {
    bit          is_done;
    logic [3:0]  pins;
    logic [1:0]  ba;
    logic [11:0] addr;
    int          gap;
    int          req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic exp_t mk(input logic [3:0] p, input logic [1:0] b,
                              input logic [11:0] a, input int g, input int r);
    exp_t e;
    e.is_done = 1'b0; e.pins = p; e.ba = b; e.addr = a; e.gap = g; e.req = r;
    return e;
  endfunction

  // driver: expected command stream for one sequence
  task automatic push_run(input logic [2:0] bl, input logic bt, input logic [2:0] cl);
    exp_t e;
    int   delta;
    q.delete();
    q.push_back(mk(P_PRE, 2'b00, 12'h400, CKENOP, 4));                       // R4
    q.push_back(mk(P_MRS, 2'b01, 12'h000, RP, 5));                           // R5
    q.push_back(mk(P_MRS, 2'b00, {3'b000, 1'b1, 1'b0, cl, bt, bl}, MRD, 6)); // R6
    q.push_back(mk(P_PRE, 2'b00, 12'h400, MRD, 4));                          // R4
    for (int i = 0; i < NREF; i++)
      q.push_back(mk(P_REF, 2'b00, 12'h000, (i == 0) ? RP : RFC, 10));       // R10
    q.push_back(mk(P_MRS, 2'b00, {3'b000, 1'b0, 1'b0, cl, bt, bl}, RFC, 6)); // R6
    delta = MRD + RP + NREF * RFC;
    e = mk(P_NOP, 2'b00, 12'h000, (LOCK - delta > MRD) ? LOCK - delta : MRD, 8); // R8
    e.is_done = 1'b1;
    q.push_back(e);
  endtask

  // monitor
  int  cyc = 0, low_cnt = 0, last_evt = 0;
  bit  prev_cke = 0, prev_done = 0;

  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; low_cnt = 0; last_evt = 0; prev_cke = 0; prev_done = 0;
    end else begin
      exp_t e;
      logic [3:0] p;
      cyc++;
      p = {cs_n, ras_n, cas_n, we_n};
      if (!cke) low_cnt++;
      if (cke && !prev_cke) begin
        check(low_cnt == STABLE, "R2", "cke low cycles", low_cnt, STABLE);
        last_evt = cyc;
      end
      if (p != P_NOP) begin
        if (q.size() == 0 || q[0].is_done) begin
          check(1'b0, "R3", "unexpected command", p, P_NOP);
        end else begin
          e = q.pop_front();
          check({p, ba, addr} == {e.pins, e.ba, e.addr}, $sformatf("R3/R%0d", e.req),
                "command word", {p, ba, addr}, {e.pins, e.ba, e.addr});
          check(cyc - last_evt == e.gap, "R7", "spacing", cyc - last_evt, e.gap);
          last_evt = cyc;
        end
      end
      if (init_done && !prev_done) begin
        if (q.size() == 0 || !q[0].is_done) begin
          check(1'b0, "R8", "early ready flag", q.size(), 0);
        end else begin
          e = q.pop_front();
          check(cyc - last_evt == e.gap, "R8", "ready delay", cyc - last_evt, e.gap);
        end
      end
      prev_cke  = cke;
      prev_done = init_done;
    end
  end

  task automatic check_reset_state();
    check({cke, cs_n, ras_n, cas_n, we_n, ba, addr, init_done} ==
          {1'b0, P_NOP, 2'b00, 12'h000, 1'b0}, "R1", "reset state",
          {cke, cs_n, ras_n, cas_n, we_n, ba, addr, init_done},
          {1'b0, P_NOP, 2'b00, 12'h000, 1'b0});
  endtask

  task automatic wait_done();
    int n = 0;
    while (!init_done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(init_done, "R8", "ready flag reached", init_done, 1);
  endtask

  task automatic check_after_done();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check({init_done, cke, cs_n, ras_n, cas_n, we_n} == {2'b11, P_NOP}, "R9",
            "idle after ready", {init_done, cke, cs_n, ras_n, cas_n, we_n}, {2'b11, P_NOP});
    end
    check(q.size() == 0, "R3", "leftover expected items", q.size(), 0);
  endtask

  task automatic run(input logic [2:0] bl, input logic bt, input logic [2:0] cl);
    @(negedge clk);
    rst <= 1'b1;
    mode_bl <= bl; mode_bt <= bt; mode_cl <= cl;
    repeat (2) @(negedge clk);
    check_reset_state();
    push_run(bl, bt, cl);
    rst <= 1'b0;
    wait_done();
    check_after_done();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check_reset_state();                      // R1 from power-on
    run(3'b011, 1'b0, 3'b011);
    run(3'b010, 1'b1, 3'b010);
    // abort a sequence part-way, then restart it
    @(negedge clk);
    rst <= 1'b1;
    mode_bl <= 3'b001; mode_bt <= 1'b1; mode_cl <= 3'b110;
    repeat (2) @(negedge clk);
    push_run(3'b001, 1'b1, 3'b110);
    rst <= 1'b0;
    repeat (STABLE + 8) @(negedge clk);
    rst <= 1'b1;
    repeat (2) @(negedge clk);
    check_reset_state();                      // R1 after mid-sequence reset
    run(3'b001, 1'b1, 3'b110);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule